// File: doc/BRIEF.md
# Per-Pin Vector Waveform Formatter

This block turns a stream of test-vector characters into timed actions on one bidirectional tester pin. It runs on a fast tick clock, where one tick is one edge-placement step. Each vector names a waveform table and a character code and gives a period length in ticks. The block looks up the character's action and its three edge positions: drive edge A, drive edge B and a strobe. Over the period it drives the pin's output-enable and output-data, and at the strobe it checks two comparator bits against the expected response.

Two drive edges per period let a single vector form a return-to-zero pulse. Since each vector brings its own table and character, edge placement can change from one period to the next without oversampling. A programmable stimulus delay shifts the drive outputs, and a separate receive delay shifts the strobe sampling. Both allow for cable and fixture propagation. The period sequencer is a two-state machine. IDLE means no period is running. RUN means the tick counter is advancing through a period. The transition IDLE->RUN happens on an accepted vector. RUN->RUN happens on the last tick when a new vector is presented. RUN->IDLE happens on the last tick when none is presented.

Top module: `vf_pin_formatter`

## Requirements
- R1: After reset, pin_oe is 0 (pin in high impedance), pin_do is 0, fail_o is 0 and the sequencer is IDLE.
- R2: A vector (vec_valid high) is accepted only while IDLE or on the last tick of the running period. Its tick 0 is the cycle after acceptance. A vector presented at any other tick is ignored.
- R3: There are 32 tables of 16 character codes, loaded through the tw_* write port. Code 0 is reserved: it produces no drive change and no compare, and writes to it are ignored.
- R4: Action codes are FH=0 (force high), FL=1 (force low), FP=2 (force previous), FZ=3 (stop forcing), CH=4 (compare high), CL=5 (compare low), CT=6 (compare three-state) and CX=7 (don't compare). At drive edge A, FH and FL enable the driver at 1 or 0. FZ, CH, CL, CT and CX release the driver (pin_oe=0). The pin outputs show the effect of an edge at tick t from the cycle after tick t, plus the stimulus delay.
- R5: FP drives the level of the most recent FH or FL. If none has occurred since reset, it drives 0.
- R6: For FH, FL and FP, drive edge B returns the driven pin to 0 (return-to-zero). If the two edges coincide, edge A wins. For all other actions, edge B has no effect.
- R7: An edge position greater than or equal to the period length is ignored. The same character with a longer period fires that edge.
- R8: At the strobe, CH fails if cmp_hi is 0, CL fails if cmp_lo is 0, and CT fails if either bit is 1. CX never fails. A failure raises fail_o for exactly one cycle, the cycle after the strobe sample.
- R9: drv_dly (0..254) delays pin_oe and pin_do by that many ticks.
- R10: rcv_dly (0..254) moves the strobe sample that many ticks after the strobe edge. The fail pulse moves with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one edge-placement step per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| tw_en | input | 1 | Table write strobe |
| tw_tbl | input | 5 | Table index to write |
| tw_chr | input | 4 | Character code to write (0 ignored) |
| tw_act | input | 3 | Action code for the entry |
| tw_ea | input | 8 | Drive edge A tick |
| tw_eb | input | 8 | Drive edge B tick |
| tw_es | input | 8 | Strobe tick |
| vec_valid | input | 1 | Vector presented this cycle |
| vec_tbl | input | 5 | Table selected by the vector |
| vec_chr | input | 4 | Character code of the vector |
| vec_len | input | 8 | Period length in ticks (0 treated as 1) |
| drv_dly | input | 8 | Stimulus delay in ticks |
| rcv_dly | input | 8 | Receive delay in ticks |
| cmp_hi | input | 1 | Pin level above the high threshold |
| cmp_lo | input | 1 | Pin level below the low threshold |
| pin_oe | output | 1 | Driver enable |
| pin_do | output | 1 | Driver data |
| fail_o | output | 1 | One-cycle compare failure pulse |

## Verification
On every cycle, the assertions check the following. The tick counter advances by one through a running period and stays below the period length. The driver only turns on while a period runs. A fail pulse always follows a delayed strobe sample. With a one-tick setting, the drive and receive delay taps show exactly the previous cycle's value. The action semantics can only be shown by the directed scenarios: return-to-zero shaping, the force-previous history, edges beyond the period, table selection, the reserved code, vector acceptance timing, and the larger delay values.

// File: rtl/vf_pkg.sv
package vf_pkg;
    localparam int TICK_W = 8;

    typedef enum logic [2:0] {
        ACT_FH = 3'd0,
        ACT_FL = 3'd1,
        ACT_FP = 3'd2,
        ACT_FZ = 3'd3,
        ACT_CH = 3'd4,
        ACT_CL = 3'd5,
        ACT_CT = 3'd6,
        ACT_CX = 3'd7
    } act_e;

    typedef struct packed {
        act_e              act;
        logic [TICK_W-1:0] ea;
        logic [TICK_W-1:0] eb;
        logic [TICK_W-1:0] es;
    } ent_t;

    // All-ones edges are never below any period length, so this entry fires nothing.
    localparam ent_t ENT_NOP = '{act: ACT_CX, ea: '1, eb: '1, es: '1};
endpackage

// File: rtl/vf_wave_table.sv
module vf_wave_table
    import vf_pkg::*;
#(
    parameter int N_TBL = 32,
    parameter int N_CHR = 16,
    localparam int TBL_W = $clog2(N_TBL),
    localparam int CHR_W = $clog2(N_CHR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [TBL_W-1:0] wtbl,
    input  logic [CHR_W-1:0] wchr,
    input  ent_t             wdata,
    input  logic [TBL_W-1:0] rtbl,
    input  logic [CHR_W-1:0] rchr,
    output ent_t             rdata
);
    localparam int DEPTH = N_TBL * N_CHR;

    ent_t mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= ENT_NOP;
        end else if (we && (wchr != '0)) begin
            mem_q[{wtbl, wchr}] <= wdata;
        end
    end

    // Code 0 is reserved and always reads as an entry with no edges.
    assign rdata = (rchr == '0) ? ENT_NOP : mem_q[{rtbl, rchr}];
endmodule

// File: rtl/vf_delay_line.sv
module vf_delay_line #(
    parameter int W     = 2,
    parameter int DLY_W = 8,
    localparam int DEPTH = 1 << DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] dly,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout
);
    logic [W-1:0]     mem_q [DEPTH];
    logic [DLY_W-1:0] wptr_q;
    logic [DLY_W-1:0] rptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            wptr_q <= '0;
        end else begin
            mem_q[wptr_q] <= din;
            wptr_q        <= wptr_q + 1'b1;
        end
    end

    assign rptr = wptr_q - dly;
    assign dout = (dly == '0) ? din : mem_q[rptr];
endmodule

// File: rtl/vf_period_fsm.sv
module vf_period_fsm
    import vf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_valid,
    input  ent_t              vec_ent,
    input  logic [TICK_W-1:0] vec_len,
    output logic              running,
    output logic [TICK_W-1:0] cur_tick,
    output logic [TICK_W-1:0] cur_len,
    output logic              drv_en,
    output logic              drv_val,
    output logic              strb_vld,
    output logic [2:0]        strb_act
);
    typedef enum logic {S_IDLE, S_RUN} st_e;

    st_e               st_q, st_d;
    logic [TICK_W-1:0] tick_q, tick_d, len_q, len_d, len_eff;
    ent_t              ent_q, ent_d;
    logic              at_last, ev_a, ev_b, is_drive, is_cmp;
    logic              en_q, val_q, last_lvl_q;

    assign len_eff = (vec_len == '0) ? TICK_W'(1) : vec_len;
    assign at_last = (st_q == S_RUN) && (tick_q == len_q - TICK_W'(1));

    // Next-state logic
    always_comb begin
        st_d   = st_q;
        tick_d = tick_q;
        len_d  = len_q;
        ent_d  = ent_q;
        unique case (st_q)
            S_IDLE: begin
                if (vec_valid) begin
                    st_d   = S_RUN;
                    tick_d = '0;
                    len_d  = len_eff;
                    ent_d  = vec_ent;
                end
            end
            S_RUN: begin
                if (at_last) begin
                    if (vec_valid) begin
                        tick_d = '0;
                        len_d  = len_eff;
                        ent_d  = vec_ent;
                    end else begin
                        st_d = S_IDLE;
                    end
                end else begin
                    tick_d = tick_q + TICK_W'(1);
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            tick_q <= '0;
            len_q  <= TICK_W'(1);
            ent_q  <= ENT_NOP;
        end else begin
            st_q   <= st_d;
            tick_q <= tick_d;
            len_q  <= len_d;
            ent_q  <= ent_d;
        end
    end

    // The tick never reaches len_q, so an edge at or beyond the period never matches.
    assign ev_a     = (st_q == S_RUN) && (tick_q == ent_q.ea);
    assign ev_b     = (st_q == S_RUN) && (tick_q == ent_q.eb);
    assign is_drive = (ent_q.act == ACT_FH) || (ent_q.act == ACT_FL) || (ent_q.act == ACT_FP);
    assign is_cmp   = (ent_q.act == ACT_CH) || (ent_q.act == ACT_CL) || (ent_q.act == ACT_CT);

    // Output process: pin drive state and remembered forced level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            val_q      <= 1'b0;
            last_lvl_q <= 1'b0;
        end else if (ev_a) begin
            unique case (ent_q.act)
                ACT_FH: begin en_q <= 1'b1; val_q <= 1'b1; last_lvl_q <= 1'b1; end
                ACT_FL: begin en_q <= 1'b1; val_q <= 1'b0; last_lvl_q <= 1'b0; end
                ACT_FP: begin en_q <= 1'b1; val_q <= last_lvl_q; end
                ACT_FZ, ACT_CH, ACT_CL, ACT_CT, ACT_CX: en_q <= 1'b0;
            endcase
        end else if (ev_b && is_drive) begin
            en_q  <= 1'b1;
            val_q <= 1'b0;
        end
    end

    assign running  = (st_q == S_RUN);
    assign cur_tick = tick_q;
    assign cur_len  = len_q;
    assign drv_en   = en_q;
    assign drv_val  = val_q;
    assign strb_vld = (st_q == S_RUN) && (tick_q == ent_q.es) && is_cmp;
    assign strb_act = ent_q.act;
endmodule

// File: rtl/vf_pin_formatter.sv
module vf_pin_formatter
    import vf_pkg::*;
#(
    parameter int N_TBL = 32,
    parameter int N_CHR = 16,
    parameter int DLY_W = 8,
    localparam int TBL_W = $clog2(N_TBL),
    localparam int CHR_W = $clog2(N_CHR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tw_en,
    input  logic [TBL_W-1:0]  tw_tbl,
    input  logic [CHR_W-1:0]  tw_chr,
    input  logic [2:0]        tw_act,
    input  logic [TICK_W-1:0] tw_ea,
    input  logic [TICK_W-1:0] tw_eb,
    input  logic [TICK_W-1:0] tw_es,
    input  logic              vec_valid,
    input  logic [TBL_W-1:0]  vec_tbl,
    input  logic [CHR_W-1:0]  vec_chr,
    input  logic [TICK_W-1:0] vec_len,
    input  logic [DLY_W-1:0]  drv_dly,
    input  logic [DLY_W-1:0]  rcv_dly,
    input  logic              cmp_hi,
    input  logic              cmp_lo,
    output logic              pin_oe,
    output logic              pin_do,
    output logic              fail_o
);
    ent_t              wr_ent, rd_ent;
    logic              running, drv_en_r, drv_val_r, strb_vld;
    logic [TICK_W-1:0] cur_tick, cur_len;
    logic [2:0]        strb_act;
    logic [3:0]        rx_bus;
    logic              rx_v, miss, fail_q;
    act_e              rx_act;

    assign wr_ent = '{act: act_e'(tw_act), ea: tw_ea, eb: tw_eb, es: tw_es};

    vf_wave_table #(.N_TBL(N_TBL), .N_CHR(N_CHR)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .we(tw_en), .wtbl(tw_tbl), .wchr(tw_chr), .wdata(wr_ent),
        .rtbl(vec_tbl), .rchr(vec_chr), .rdata(rd_ent)
    );

    vf_period_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .vec_valid(vec_valid), .vec_ent(rd_ent), .vec_len(vec_len),
        .running(running), .cur_tick(cur_tick), .cur_len(cur_len),
        .drv_en(drv_en_r), .drv_val(drv_val_r),
        .strb_vld(strb_vld), .strb_act(strb_act)
    );

    vf_delay_line #(.W(2), .DLY_W(DLY_W)) u_drv_dly (
        .clk(clk), .rst_n(rst_n), .dly(drv_dly),
        .din({drv_en_r, drv_val_r}), .dout({pin_oe, pin_do})
    );

    vf_delay_line #(.W(4), .DLY_W(DLY_W)) u_rcv_dly (
        .clk(clk), .rst_n(rst_n), .dly(rcv_dly),
        .din({strb_vld, strb_act}), .dout(rx_bus)
    );

    assign rx_v   = rx_bus[3];
    assign rx_act = act_e'(rx_bus[2:0]);

    always_comb begin
        case (rx_act)
            ACT_CH:  miss = !cmp_hi;
            ACT_CL:  miss = !cmp_lo;
            ACT_CT:  miss = cmp_hi | cmp_lo;
            default: miss = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fail_q <= 1'b0;
        else        fail_q <= rx_v && miss;
    end

    assign fail_o = fail_q;
endmodule

// File: rtl/vf_pin_formatter_chk.sv
module vf_pin_formatter_chk
    import vf_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              running,
    input logic [TICK_W-1:0] cur_tick,
    input logic [TICK_W-1:0] cur_len,
    input logic              drv_en_r,
    input logic [DLY_W-1:0]  drv_dly,
    input logic              pin_oe,
    input logic              strb_vld,
    input logic [DLY_W-1:0]  rcv_dly,
    input logic              rx_v,
    input logic              fail_o
);
    // R2: within a period the tick steps by one
    a_r2_tick_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && cur_tick != '0) |-> cur_tick == TICK_W'($past(cur_tick) + 1'b1));

    // R7: the tick stays below the period length, so no edge beyond it can fire
    a_r7_tick_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> cur_tick < cur_len);

    // R4: the driver only switches on out of a running period
    a_r4_drive_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en_r) |-> $past(running));

    // R9: a one-tick stimulus delay shows last cycle's driver enable
    a_r9_one_tick_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_dly == DLY_W'(1) && $past(drv_dly) == DLY_W'(1)) |-> pin_oe == $past(drv_en_r));

    // R10: a one-tick receive delay shows last cycle's strobe
    a_r10_one_tick_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_dly == DLY_W'(1) && $past(rcv_dly) == DLY_W'(1)) |-> rx_v == $past(strb_vld));

    // R8: a fail pulse always follows a delayed strobe sample
    a_r8_fail_source: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> $past(rx_v));
endmodule

bind vf_pin_formatter vf_pin_formatter_chk #(.DLY_W(DLY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .cur_tick(cur_tick),
    .cur_len(cur_len), .drv_en_r(drv_en_r), .drv_dly(drv_dly), .pin_oe(pin_oe),
    .strb_vld(strb_vld), .rcv_dly(rcv_dly), .rx_v(rx_v), .fail_o(fail_o)
);

// File: tb/vf_pin_formatter_tb.sv
`timescale 1ns/1ps
module vf_pin_formatter_tb;
    localparam logic [2:0] FH = 3'd0, FL = 3'd1, FP = 3'd2, FZ = 3'd3;
    localparam logic [2:0] CH = 3'd4, CL = 3'd5, CT = 3'd6, CX = 3'd7;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       tw_en = 1'b0;
    logic [4:0] tw_tbl = '0, vec_tbl = '0;
    logic [3:0] tw_chr = '0, vec_chr = '0;
    logic [2:0] tw_act = '0;
    logic [7:0] tw_ea = '0, tw_eb = '0, tw_es = '0, vec_len = '0;
    logic       vec_valid = 1'b0;
    logic [7:0] drv_dly = '0, rcv_dly = '0;
    logic       cmp_hi = 1'b0, cmp_lo = 1'b0;
    logic       pin_oe, pin_do, fail_o;

    int n_cmp = 0;
    int n_mis = 0;

    vf_pin_formatter u_dut (
        .clk(clk), .rst_n(rst_n), .tw_en(tw_en), .tw_tbl(tw_tbl), .tw_chr(tw_chr),
        .tw_act(tw_act), .tw_ea(tw_ea), .tw_eb(tw_eb), .tw_es(tw_es),
        .vec_valid(vec_valid), .vec_tbl(vec_tbl), .vec_chr(vec_chr), .vec_len(vec_len),
        .drv_dly(drv_dly), .rcv_dly(rcv_dly), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
        .pin_oe(pin_oe), .pin_do(pin_do), .fail_o(fail_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_mis++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [4:0] t, input logic [3:0] c, input logic [2:0] a,
                        input logic [7:0] ea, input logic [7:0] eb, input logic [7:0] es);
        @(negedge clk);
        tw_en = 1'b1; tw_tbl = t; tw_chr = c; tw_act = a; tw_ea = ea; tw_eb = eb; tw_es = es;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    // Called at a falling edge; returns at the falling edge after the accepting clock edge.
    task automatic start(input logic [4:0] t, input logic [3:0] c, input logic [7:0] len);
        vec_valid = 1'b1; vec_tbl = t; vec_chr = c; vec_len = len;
        @(negedge clk);
        vec_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 pin_oe after reset", pin_oe, 0);
        check("R1 pin_do after reset", pin_do, 0);
        check("R1 fail_o after reset", fail_o, 0);
    endtask

    task automatic t_fp_from_reset();
        start(1, 3, 4); adv(1);
        check("R5 force-previous enables driver", pin_oe, 1);
        check("R5 force-previous with no history drives 0", pin_do, 0);
        adv(4);
    endtask

    task automatic t_nrz();
        start(1, 1, 8); adv(2);
        check("R4 level before edge A", pin_do, 0);
        adv(1);
        check("R4 force high enables", pin_oe, 1);
        check("R4 force high level", pin_do, 1);
        adv(7);
        check("R4 level held after period", pin_do, 1);
    endtask

    task automatic t_rz();
        start(1, 2, 8); adv(2);
        check("R6 pulse high after edge A", pin_do, 1);
        adv(3);
        check("R6 edge B returns to 0", pin_do, 0);
        check("R6 driver stays on after edge B", pin_oe, 1);
        adv(4);
    endtask

    task automatic t_fp_history();
        start(1, 10, 6); adv(1);
        check("R5 force-previous repeats last forced 1", pin_do, 1);
        adv(2);
        check("R6 edge B returns force-previous to 0", pin_do, 0);
        adv(4);
    endtask

    task automatic t_edge_len();
        start(1, 5, 3); adv(1);
        check("R4 stop forcing releases pin", pin_oe, 0);
        adv(3);
        start(1, 4, 5); adv(7);
        check("R7 edge at 6 ignored in 5-tick period", pin_oe, 0);
        start(1, 4, 8); adv(6);
        check("R7 edge at 6 not yet applied", pin_oe, 0);
        adv(1);
        check("R7 edge at 6 fires in 8-tick period", pin_oe, 1);
        adv(2);
    endtask

    task automatic t_tables();
        int seen;
        start(7, 1, 4); adv(1);
        check("R3 table 7 code 1 forces low", pin_oe, 1);
        check("R3 table 7 code 1 level", pin_do, 0);
        adv(4);
        start(1, 5, 3); adv(4);
        cmp_hi = 1'b0; cmp_lo = 1'b1;
        seen = 0;
        start(0, 0, 6);
        for (int k = 0; k < 7; k++) begin
            adv(1);
            if (fail_o) seen++;
        end
        check("R3 code 0 leaves pin released", pin_oe, 0);
        check("R3 code 0 makes no compare", seen, 0);
        cmp_lo = 1'b0;
    endtask

    task automatic run_cmp(input string req, input logic [3:0] c, input logic hi,
                           input logic lo, input logic expf);
        cmp_hi = hi; cmp_lo = lo;
        start(1, c, 6); adv(1);
        check({req, " driver released"}, pin_oe, 0);
        adv(2);
        check({req, " no fail before strobe"}, fail_o, 0);
        adv(1);
        check({req, " fail after strobe"}, fail_o, expf);
        adv(1);
        check({req, " fail lasts one cycle"}, fail_o, 0);
        adv(2);
    endtask

    task automatic t_compare();
        run_cmp("R8 CH pass", 6, 1, 0, 0);
        run_cmp("R8 CH miss", 6, 0, 0, 1);
        run_cmp("R8 CL pass", 7, 0, 1, 0);
        run_cmp("R8 CL miss", 7, 0, 0, 1);
        run_cmp("R8 CT pass", 8, 0, 0, 0);
        run_cmp("R8 CT high", 8, 1, 0, 1);
        run_cmp("R8 CT low", 8, 0, 1, 1);
        run_cmp("R8 CX never fails", 9, 1, 1, 0);
        cmp_hi = 1'b0; cmp_lo = 1'b0;
    endtask

    task automatic t_accept();
        start(1, 5, 2); adv(1);
        start(1, 11, 4);
        check("R2 back-to-back: previous release still seen", pin_oe, 0);
        adv(1);
        check("R2 back-to-back vector applied at its tick 0", pin_oe, 1);
        adv(4);
        start(1, 5, 6); adv(2);
        start(1, 11, 4); adv(5);
        check("R2 vector mid-period ignored", pin_oe, 0);
    endtask

    task automatic t_drv_delay();
        start(1, 5, 3); adv(4);
        drv_dly = 8'd3; adv(4);
        start(1, 11, 8); adv(3);
        check("R9 drive held back by delay", pin_oe, 0);
        adv(1);
        check("R9 drive appears after 3 ticks", pin_oe, 1);
        adv(5);
        start(1, 5, 3); adv(8);
        drv_dly = 8'd0; adv(4);
    endtask

    task automatic t_rcv_delay();
        cmp_hi = 1'b1; cmp_lo = 1'b0; rcv_dly = 8'd2; adv(3);
        start(1, 6, 8); adv(4);
        check("R10 no fail at undelayed strobe", fail_o, 0);
        adv(1);
        cmp_hi = 1'b0;
        adv(1);
        cmp_hi = 1'b1;
        check("R10 delayed sample catches miss", fail_o, 1);
        adv(1);
        check("R10 fail one cycle", fail_o, 0);
        adv(3);
        rcv_dly = 8'd0; adv(3);
    endtask

    initial begin
        #(5.0 * 100000);
        n_mis++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        adv(4);
        rst_n = 1'b1;
        adv(1);
        t_reset();
        load(1, 1, FH, 8'd2, 8'd255, 8'd255);
        load(1, 2, FH, 8'd1, 8'd4, 8'd255);
        load(1, 3, FP, 8'd0, 8'd255, 8'd255);
        load(1, 4, FH, 8'd6, 8'd255, 8'd255);
        load(1, 5, FZ, 8'd0, 8'd255, 8'd255);
        load(1, 6, CH, 8'd0, 8'd255, 8'd3);
        load(1, 7, CL, 8'd0, 8'd255, 8'd3);
        load(1, 8, CT, 8'd0, 8'd255, 8'd3);
        load(1, 9, CX, 8'd0, 8'd255, 8'd3);
        load(1, 10, FP, 8'd0, 8'd2, 8'd255);
        load(1, 11, FH, 8'd0, 8'd255, 8'd255);
        load(7, 1, FL, 8'd0, 8'd255, 8'd255);
        load(0, 0, FH, 8'd0, 8'd255, 8'd255);
        t_fp_from_reset();
        t_nrz();
        t_rz();
        t_fp_history();
        t_edge_len();
        t_tables();
        t_compare();
        t_accept();
        t_drv_delay();
        t_rcv_delay();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule